// File: doc/BRIEF.md
# Serial Character Receiver with Address Filtering

This block turns an asynchronous serial line into characters and holds them in a small queue until a consumer takes them. A free-running tick at sixteen times the bit rate drives the sampling. Each frame is a low start bit, then eight or nine data bits with the least significant bit first, then an optional parity bit in 8-bit mode, then a stop bit. Every completed character is stored together with its own parity-error and framing-error flags. The status outputs for those flags always describe the character that is next to be read.

In 9-bit mode the ninth bit can mark a character as an address. When address filtering is enabled, the block keeps only address characters and discards data characters. This lets one receiver on a shared multi-drop line ignore traffic meant for other nodes. If a character arrives while the queue is full, an overrun flag is raised and the character is lost. Software clears the flag by writing 0 to it, and that same write empties the queue and resets the bit engine.

Characters leave through a valid/ready port. `rd_valid` stays high while the queue holds anything. `rd_data` and the head flags stay steady until the consumer raises `rd_ready` while `rd_valid` is high, and the head is then popped on that clock edge. Configuration is written through a single write strobe, which loads all fields at once.

Top module: `uart_rx_addrsel`

## Requirements
- R1: After reset, `stat_avail`=0, `rd_valid`=0, `stat_idle`=1, `stat_ovf`=0, `stat_perr`=0 and `stat_ferr`=0. Configuration resets to 8-bit mode, no parity and filtering off.
- R2: An 8-bit frame is received least significant bit first. It is queued with `rd_data[8]`=0, and characters are read out in arrival order. `stat_avail` is 1 exactly when at least one character is queued.
- R3: `wr_data[1:0]` sets the parity mode: 00 means none, 01 even, 10 odd and 11 none. In 8-bit mode with even or odd parity, a parity bit follows the data. A mismatch sets the character's parity flag. With even parity the data ones plus the parity bit must add up to an even count; with odd parity they must add up to an odd count.
- R4: A stop bit sampled low sets the character's framing flag.
- R5: `stat_perr` and `stat_ferr` show the flags of the head character, not of the latest arrival. Both read 0 when the queue is empty.
- R6: When `wr_data[2]`=1 (9-bit mode), nine data bits are received and no parity bit follows them, whatever the parity mode. The parity flag is then 0.
- R7: When `wr_data[3]`=1 (filter enable) and the block is in 9-bit mode, characters with bit 8 = 0 are discarded. Characters with bit 8 = 1 are queued.
- R8: In 8-bit mode the filter enable has no effect, and every character is queued.
- R9: A character accepted while 4 characters are queued sets `stat_ovf`. That character is dropped and the queued ones are kept. While `stat_ovf` is 1, nothing is queued.
- R10: `wr_data[4]` is the overrun bit. Writing 1 leaves it unchanged. Writing 0 while it is set clears it, empties the queue and returns the bit engine to idle, all effective at the next clock edge.
- R11: `stat_idle` is 0 from start-bit detection until the stop bit is sampled, and 1 otherwise. A start bit that reads high at mid-bit is abandoned and no character is produced.
- R12: While `rd_valid`=1 and `rd_ready`=0, `rd_valid`, `rd_data`, `stat_perr` and `stat_ferr` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_i | input | 1 | Serial line, idle high |
| wr_en | input | 1 | Configuration write strobe |
| wr_data | input | 5 | {ovf bit, filter enable, 9-bit mode, parity mode[1:0]} |
| rd_valid | output | 1 | Head character present |
| rd_ready | input | 1 | Consumer takes head character |
| rd_data | output | 9 | Head character data |
| stat_avail | output | 1 | Data-available status |
| stat_idle | output | 1 | Receiver idle status |
| stat_perr | output | 1 | Parity flag of head character |
| stat_ferr | output | 1 | Framing flag of head character |
| stat_ovf | output | 1 | Overrun status |

## Verification
The line passes through a two-flop synchronizer. A character is queued one clock after its stop bit is sampled at mid-bit, so `rd_valid` rises at most a few cycles after the middle of the stop bit. The bench therefore waits for `rd_valid` with a bound and does not count a fixed number of cycles. Pops and overrun-clearing writes take effect at the next edge, so their results are sampled on the falling edge that follows. Each frame is followed by two idle bit times, so that the status checks made after a frame see a settled receiver.

// File: rtl/uart_rxaf_pkg.sv
package uart_rxaf_pkg;
  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_EVEN = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_RSVD = 2'b11
  } par_mode_e;

  typedef struct packed {
    logic [8:0] data;
    logic       perr;
    logic       ferr;
  } rx_char_t;

  typedef struct packed {
    logic      addr_en;
    logic      nine_bit;
    par_mode_e par;
  } rx_cfg_t;

  localparam int CHAR_W = $bits(rx_char_t);
endpackage

// File: rtl/rxa_sync.sv
module rxa_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '1;
    else        sr <= {sr[STAGES-2:0], d_i};
  end

  assign q_o = sr[STAGES-1];
endmodule

// File: rtl/rxa_framer.sv
module rxa_framer
  import uart_rxaf_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     flush_i,
  input  logic     tick_i,
  input  logic     rx_i,
  input  rx_cfg_t  cfg_i,
  output logic     busy_o,
  output logic     char_valid_o,
  output rx_char_t char_o
);
  localparam int CW  = $clog2(OSR);
  localparam int MID = OSR / 2 - 1;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} fr_state_e;

  fr_state_e   state;
  logic [CW-1:0] cnt;
  logic [3:0]  bidx;
  logic [8:0]  sh;
  logic        par_acc;
  logic        perr_q;
  logic        f_nine;
  logic        f_par_en;
  logic        f_odd;
  logic        last_bit;
  logic        mid_pt;
  logic        bit_end;

  assign last_bit = f_nine ? (bidx == 4'd8) : (bidx == 4'd7);
  assign mid_pt   = (cnt == CW'(MID));
  assign bit_end  = (cnt == CW'(OSR - 1));
  assign busy_o   = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      cnt          <= '0;
      bidx         <= '0;
      sh           <= '0;
      par_acc      <= 1'b0;
      perr_q       <= 1'b0;
      f_nine       <= 1'b0;
      f_par_en     <= 1'b0;
      f_odd        <= 1'b0;
      char_valid_o <= 1'b0;
      char_o       <= '0;
    end else if (flush_i) begin
      state        <= S_IDLE;
      cnt          <= '0;
      bidx         <= '0;
      char_valid_o <= 1'b0;
    end else begin
      char_valid_o <= 1'b0;
      if (tick_i) begin
        case (state)
          S_IDLE: begin
            if (!rx_i) begin
              state    <= S_START;
              cnt      <= '0;
              f_nine   <= cfg_i.nine_bit;
              f_par_en <= !cfg_i.nine_bit &&
                          (cfg_i.par == PAR_EVEN || cfg_i.par == PAR_ODD);
              f_odd    <= (cfg_i.par == PAR_ODD);
            end
          end
          S_START: begin
            if (mid_pt) begin
              cnt <= '0;
              if (!rx_i) begin
                state   <= S_DATA;
                bidx    <= '0;
                sh      <= '0;
                par_acc <= 1'b0;
                perr_q  <= 1'b0;
              end else begin
                state <= S_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_DATA: begin
            if (bit_end) begin
              cnt      <= '0;
              sh[bidx] <= rx_i;
              par_acc  <= par_acc ^ rx_i;
              if (last_bit) state <= f_par_en ? S_PAR : S_STOP;
              else          bidx  <= bidx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_PAR: begin
            if (bit_end) begin
              cnt    <= '0;
              perr_q <= par_acc ^ rx_i ^ f_odd;
              state  <= S_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_STOP: begin
            if (bit_end) begin
              cnt          <= '0;
              char_valid_o <= 1'b1;
              char_o       <= '{data: sh, perr: perr_q, ferr: !rx_i};
              state        <= S_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rxa_admit.sv
module rxa_admit
  import uart_rxaf_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     char_valid_i,
  input  rx_char_t char_i,
  input  rx_cfg_t  cfg_i,
  input  logic     full_i,
  input  logic     clr_req_i,
  output logic     push_o,
  output logic     flush_o,
  output logic     ovf_o
);
  logic ovf_q;
  logic accept;
  logic drop_addr;

  assign drop_addr = cfg_i.nine_bit && cfg_i.addr_en && !char_i.data[8];
  assign accept    = char_valid_i && !drop_addr;
  assign push_o    = accept && !ovf_q && !full_i;
  assign flush_o   = clr_req_i && ovf_q;
  assign ovf_o     = ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          ovf_q <= 1'b0;
    else if (flush_o)                    ovf_q <= 1'b0;
    else if (accept && !ovf_q && full_i) ovf_q <= 1'b1;
  end
endmodule

// File: rtl/rxa_fifo.sv
module rxa_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         valid_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic [AW:0]   count;
  logic          do_pop;

  assign valid_o = (count != '0);
  assign full_o  = (count == (AW+1)'(DEPTH));
  assign do_pop  = pop_i && valid_o;
  assign head_o  = mem[rd_ptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                         mem[g] <= '0;
      else if (push_i && !flush_i && wr_ptr == AW'(g))    mem[g] <= din_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || flush_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_i) wr_ptr <= nxt(wr_ptr);
      if (do_pop) rd_ptr <= nxt(rd_ptr);
      case ({push_i, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_addrsel.sv
module uart_rx_addrsel
  import uart_rxaf_pkg::*;
#(
  parameter int DEPTH     = 4,
  parameter int OSR       = 16,
  parameter int SYNC_STGS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       rx_i,
  input  logic       wr_en,
  input  logic [4:0] wr_data,
  output logic       rd_valid,
  input  logic       rd_ready,
  output logic [8:0] rd_data,
  output logic       stat_avail,
  output logic       stat_idle,
  output logic       stat_perr,
  output logic       stat_ferr,
  output logic       stat_ovf
);
  localparam int OVF_BIT = 4;

  rx_cfg_t  cfg_q;
  logic     rx_s;
  logic     busy;
  logic     ch_valid;
  rx_char_t ch;
  logic     full;
  logic     push;
  logic     flush;
  logic     clr_req;
  logic     fifo_valid;
  rx_char_t head;
  logic [CHAR_W-1:0] head_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '{addr_en: 1'b0, nine_bit: 1'b0, par: PAR_NONE};
    else if (wr_en)  cfg_q <= '{addr_en: wr_data[3], nine_bit: wr_data[2],
                                par: par_mode_e'(wr_data[1:0])};
  end

  assign clr_req = wr_en && !wr_data[OVF_BIT];

  rxa_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(rx_i), .q_o(rx_s)
  );

  rxa_framer #(.OSR(OSR)) u_framer (
    .clk(clk), .rst_n(rst_n), .flush_i(flush), .tick_i(baud_tick),
    .rx_i(rx_s), .cfg_i(cfg_q), .busy_o(busy),
    .char_valid_o(ch_valid), .char_o(ch)
  );

  rxa_admit u_admit (
    .clk(clk), .rst_n(rst_n), .char_valid_i(ch_valid), .char_i(ch),
    .cfg_i(cfg_q), .full_i(full), .clr_req_i(clr_req),
    .push_o(push), .flush_o(flush), .ovf_o(stat_ovf)
  );

  rxa_fifo #(.DEPTH(DEPTH), .W(CHAR_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush_i(flush), .push_i(push),
    .din_i(ch), .pop_i(rd_ready), .head_o(head_bits),
    .valid_o(fifo_valid), .full_o(full)
  );

  assign head       = rx_char_t'(head_bits);
  assign rd_valid   = fifo_valid;
  assign rd_data    = head.data;
  assign stat_avail = fifo_valid;
  assign stat_idle  = !busy;
  assign stat_perr  = fifo_valid && head.perr;
  assign stat_ferr  = fifo_valid && head.ferr;
endmodule

// File: rtl/rxa_checker.sv
module rxa_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [4:0] wr_data,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [8:0] rd_data,
  input logic       stat_idle,
  input logic       stat_perr,
  input logic       stat_ferr,
  input logic       stat_ovf
);
  logic clr_hit;
  assign clr_hit = wr_en && !wr_data[4] && stat_ovf;

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_ovf && !(wr_en && !wr_data[4]) |=> stat_ovf);

  p_ovf_needs_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_ovf) |-> rd_valid);

  p_clear_flushes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> !rd_valid && !stat_ovf && stat_idle);

  p_flags_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> !stat_perr && !stat_ferr);

  p_hold_head_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready && !clr_hit |=>
      rd_valid && $stable(rd_data) && $stable(stat_perr) && $stable(stat_ferr));
endmodule

bind uart_rx_addrsel rxa_checker u_rxa_checker (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
  .stat_idle(stat_idle), .stat_perr(stat_perr), .stat_ferr(stat_ferr),
  .stat_ovf(stat_ovf)
);

// File: tb/test_uart_rx_addrsel.sv
`timescale 1ns/1ps
module test_uart_rx_addrsel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       rx_i = 1'b1;
  logic       wr_en = 1'b0;
  logic [4:0] wr_data = '0;
  logic       rd_valid;
  logic       rd_ready = 1'b0;
  logic [8:0] rd_data;
  logic       stat_avail, stat_idle, stat_perr, stat_ferr, stat_ovf;

  int vectors = 0;
  int miscompares = 0;
  logic [1:0] tick_cnt = '0;

  typedef struct { logic [8:0] d; bit pe; bit fe; } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  always @(posedge clk) begin
    tick_cnt  <= tick_cnt + 1'b1;
    baud_tick <= (tick_cnt == 2'd3);
  end

  uart_rx_addrsel i_uart_rx_addrsel (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_i(rx_i),
    .wr_en(wr_en), .wr_data(wr_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .stat_avail(stat_avail),
    .stat_idle(stat_idle), .stat_perr(stat_perr), .stat_ferr(stat_ferr),
    .stat_ovf(stat_ovf)
  );

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wcfg(input bit keep_ovf, input bit aen, input bit nine,
                      input logic [1:0] par);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = {keep_ovf, aen, nine, par};
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic expect_char(input logic [8:0] d, input bit pe, input bit fe);
    exp_t e;
    e.d = d; e.pe = pe; e.fe = fe;
    exp_q.push_back(e);
  endtask

  task automatic send_frame(input logic [8:0] d, input int nb, input bit use_par,
                            input bit pbit, input bit stopv, input bit chk_idle);
    @(negedge clk);
    rx_i = 1'b0;
    if (chk_idle) begin
      repeat (48) @(negedge clk);
      check("R11 idle low during frame", stat_idle, 0);
      repeat (16) @(negedge clk);
    end else begin
      repeat (64) @(negedge clk);
    end
    for (int i = 0; i < nb; i++) begin
      rx_i = d[i];
      repeat (64) @(negedge clk);
    end
    if (use_par) begin
      rx_i = pbit;
      repeat (64) @(negedge clk);
    end
    rx_i = stopv;
    if (!stopv) begin
      repeat (44) @(negedge clk);
      rx_i = 1'b1;
      repeat (20) @(negedge clk);
    end else begin
      repeat (64) @(negedge clk);
    end
    rx_i = 1'b1;
    repeat (128) @(negedge clk);
    if (chk_idle) check("R11 idle after stop", stat_idle, 1);
  endtask

  task automatic drain();
    exp_t e;
    logic [8:0] held;
    while (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      for (int t = 0; t < 2000 && !rd_valid; t++) @(negedge clk);
      check("R2 rd_valid with character due", rd_valid, 1);
      check("R2 stat_avail with character", stat_avail, 1);
      check("R2 data order", rd_data, e.d);
      check("R5 head parity flag (R3)", stat_perr, e.pe);
      check("R5 head framing flag (R4)", stat_ferr, e.fe);
      held = rd_data;
      repeat (3) @(negedge clk);
      check("R12 valid held without ready", rd_valid, 1);
      check("R12 data held without ready", rd_data, held);
      rd_ready = 1'b1;
      @(negedge clk);
      rd_ready = 1'b0;
    end
    @(negedge clk);
    check("R2 avail low after draining", stat_avail, 0);
    check("R5 perr low when empty", stat_perr, 0);
    check("R5 ferr low when empty", stat_ferr, 0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 avail", stat_avail, 0);
    check("R1 rd_valid", rd_valid, 0);
    check("R1 idle", stat_idle, 1);
    check("R1 ovf", stat_ovf, 0);
    check("R1 perr", stat_perr, 0);
    check("R1 ferr", stat_ferr, 0);

    // R2 plain 8-bit, R11 idle tracking
    send_frame(9'h0A5, 8, 0, 0, 1, 1); expect_char(9'h0A5, 0, 0);
    send_frame(9'h03C, 8, 0, 0, 1, 0); expect_char(9'h03C, 0, 0);
    drain();

    // R3 even parity then odd parity; R5 head vs latest
    wcfg(1, 0, 0, 2'b01);
    send_frame(9'h05A, 8, 1, 0, 1, 0); expect_char(9'h05A, 0, 0);
    send_frame(9'h007, 8, 1, 0, 1, 0); expect_char(9'h007, 1, 0);
    send_frame(9'h007, 8, 1, 1, 1, 0); expect_char(9'h007, 0, 0);
    drain();
    wcfg(1, 0, 0, 2'b10);
    send_frame(9'h001, 8, 1, 0, 1, 0); expect_char(9'h001, 0, 0);
    send_frame(9'h001, 8, 1, 1, 1, 0); expect_char(9'h001, 1, 0);
    drain();

    // R4 framing flag travels with its character
    wcfg(1, 0, 0, 2'b00);
    send_frame(9'h0C3, 8, 0, 0, 0, 0); expect_char(9'h0C3, 0, 1);
    send_frame(9'h011, 8, 0, 0, 1, 0); expect_char(9'h011, 0, 0);
    drain();

    // R6 nine-bit mode, parity setting ignored
    wcfg(1, 0, 1, 2'b01);
    send_frame(9'h1FF, 9, 0, 0, 1, 0); expect_char(9'h1FF, 0, 0);
    send_frame(9'h0AB, 9, 0, 0, 1, 0); expect_char(9'h0AB, 0, 0);
    drain();

    // R7 address filter in nine-bit mode
    wcfg(1, 1, 1, 2'b00);
    send_frame(9'h155, 9, 0, 0, 1, 0); expect_char(9'h155, 0, 0);
    send_frame(9'h055, 9, 0, 0, 1, 0);
    send_frame(9'h100, 9, 0, 0, 1, 0); expect_char(9'h100, 0, 0);
    drain();

    // R8 filter enable without nine-bit mode
    wcfg(1, 1, 0, 2'b00);
    send_frame(9'h012, 8, 0, 0, 1, 0); expect_char(9'h012, 0, 0);
    drain();

    // R9 overrun keeps old entries, drops new ones
    wcfg(1, 0, 0, 2'b00);
    for (int k = 1; k <= 4; k++) begin
      send_frame(9'(k), 8, 0, 0, 1, 0);
      expect_char(9'(k), 0, 0);
    end
    check("R9 no overrun at exactly full", stat_ovf, 0);
    send_frame(9'h005, 8, 0, 0, 1, 0);
    check("R9 overrun set on fifth", stat_ovf, 1);
    send_frame(9'h006, 8, 0, 0, 1, 0);
    wcfg(1, 0, 0, 2'b00);
    check("R10 writing 1 keeps overrun", stat_ovf, 1);
    drain();
    check("R9 overrun still set after drain", stat_ovf, 1);
    send_frame(9'h007, 8, 0, 0, 1, 0);
    check("R9 nothing queued while overrun", stat_avail, 0);
    wcfg(0, 0, 0, 2'b00);
    check("R10 overrun cleared by writing 0", stat_ovf, 0);
    send_frame(9'h008, 8, 0, 0, 1, 0); expect_char(9'h008, 0, 0);
    drain();

    // R10 clear flushes a full queue
    for (int k = 0; k < 5; k++) send_frame(9'h040 + 9'(k), 8, 0, 0, 1, 0);
    check("R9 overrun before flush", stat_ovf, 1);
    @(negedge clk);
    wr_en = 1'b1; wr_data = 5'b0_0000;
    @(negedge clk);
    wr_en = 1'b0;
    check("R10 queue empty after clear", stat_avail, 0);
    check("R10 overrun low after clear", stat_ovf, 0);
    check("R10 receiver idle after clear", stat_idle, 1);
    send_frame(9'h09E, 8, 0, 0, 1, 0); expect_char(9'h09E, 0, 0);
    drain();

    // R11 false start
    @(negedge clk);
    rx_i = 1'b0;
    repeat (12) @(negedge clk);
    rx_i = 1'b1;
    repeat (300) @(negedge clk);
    check("R11 idle after false start", stat_idle, 1);
    check("R11 no character from false start", stat_avail, 0);

    finish_run();
  end
endmodule